// File: doc/BRIEF.md
# Video-Priority Bus Arbiter

This block decides, one bus cycle at a time, whether a shared memory bus belongs to the processor or to the video controller. Each bus cycle is one period of a phase clock. Its low half always goes to the video side, and its high half normally goes to the processor. Two outputs carry the decision. The bus-ready output (`bus_ready`) is the stall line for the processor: when it is low the processor must halt. The address-grant output (`addr_grant`) is high when the processor may drive the address bus. When it is low, the video side owns the address bus.

The video side sometimes needs whole cycles, including the processor half. This happens on long-fetch lines, which read a row of display pointers, and for the two data cycles of each enabled sprite. The processor cannot be frozen in the middle of a write. For that reason every takeover is announced on `bus_ready` three bus cycles before the first cycle it claims. The arbiter finds long-fetch lines from the scanline number, the vertical fine-scroll value and the display enable. Each sprite has an enable and a slot indicator that announces when that sprite's fetch is due. Requests that overlap are queued, so their fetch cycles run back to back.

The block runs on the dot clock. It samples the phase clock level and acts on the phase clock's edges, so both outputs change only just after a phase edge. The line-start pulse marks cycle 0 of each scanline.

Top module: `vpa_arbiter`

## Requirements
- R1: While reset is high, `bus_ready` and `addr_grant` are both 1.
- R2: In a bus cycle that claims no fetch and is inside no announcement window, `addr_grant` is 0 during the phase-low half and 1 during the phase-high half, and `bus_ready` is 1.
- R3: A line is a long-fetch line only when all three of these hold: `disp_on` is 1, `scan_line` lies in 0x30..0xF7 inclusive, and `scan_line[2:0]` equals `fine_scroll`. The values are sampled in the cycle in which `line_start` is 1.
- R4: `bus_ready` is 0 in every bus cycle from three cycles before a claimed fetch cycle through that fetch cycle. During those three lead cycles, `addr_grant` stays 1 in the phase-high half.
- R5: The cycle in which `line_start` is sampled as 1 is cycle 0. On a long-fetch line, the video side claims the 40 consecutive bus cycles 15..54, and `addr_grant` is 0 in both halves of each of them.
- R6: A sprite whose `spr_slot` bit and `spr_on` bit are both 1 in bus cycle c claims cycles c+3 and c+4. A slot bit whose sprite is disabled claims nothing.
- R7: When requests overlap or arrive in the same cycle, their claimed cycles are granted one after another with no gap, in arrival order.
- R8: `bus_ready` returns to 1 in the first cycle after the last claimed cycle, provided no further claim lies within three cycles. In that cycle, `addr_grant` is 1 in the phase-high half.
- R9: `bus_ready` changes only on the dot-clock edge that follows a falling phase edge. `addr_grant` changes only on the dot-clock edges that follow phase edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| phi0 | input | 1 | Phase clock level (dot clock / 8, 1:1 duty) |
| line_start | input | 1 | High for the first bus cycle of a scanline |
| scan_line | input | 9 | Current scanline number |
| fine_scroll | input | 3 | Vertical fine-scroll compare value |
| disp_on | input | 1 | Display enable |
| spr_on | input | 8 | Per-sprite enable |
| spr_slot | input | 8 | Per-sprite fetch-due indicator |
| bus_ready | output | 1 | Low stalls the processor |
| addr_grant | output | 1 | High lets the processor drive the address bus |

## Verification
The hardest situation to reach is a claim that must queue behind a fetch that is already running. An example is a group of sprites that announce together while a long-fetch line still holds the bus, or whose cycles spill into the next line. The sweep builds these cases on purpose. It places staggered sprite slots near the end of long-fetch lines, and it fires all sprite slots in one cycle in the middle of a line. An arithmetic model in the bench lays every claim after the last granted cycle, and the bench compares both outputs in both halves of every bus cycle against that model.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

    localparam int LINE_W   = 9;
    localparam int SCROLL_W = 3;

    typedef logic [LINE_W-1:0]   line_t;
    typedef logic [SCROLL_W-1:0] scroll_t;

    // Edge strobes of the phase clock, one dot-clock cycle wide
    typedef struct packed {
        logic fall;
        logic rise;
    } phase_edge_t;

    // Long-fetch qualification for one scanline
    function automatic logic long_line_hit(
        input line_t   line,
        input scroll_t scroll,
        input logic    enable,
        input line_t   first,
        input line_t   last
    );
        logic in_band;
        in_band = (line >= first) && (line <= last);
        return enable && in_band && (line[SCROLL_W-1:0] == scroll);
    endfunction

endpackage

// File: rtl/vpa_phase.sv
module vpa_phase
    import vpa_pkg::*;
#(
    parameter int CYC_PER_LINE = 63,
    localparam int CYC_W = $clog2(CYC_PER_LINE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phi0,
    input  logic             line_start,
    output phase_edge_t      edge_s,
    output logic             hi_q,
    output logic [CYC_W-1:0] cyc_n
);

    logic             phi0_q;
    logic [CYC_W-1:0] cyc_q;

    always_comb begin
        edge_s.fall = phi0_q & ~phi0;
        edge_s.rise = ~phi0_q & phi0;
    end

    always_comb begin
        if (line_start)
            cyc_n = '0;
        else if (cyc_q == CYC_W'(CYC_PER_LINE - 1))
            cyc_n = '0;
        else
            cyc_n = cyc_q + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phi0_q <= phi0;
            hi_q   <= 1'b0;
            cyc_q  <= '0;
        end else begin
            phi0_q <= phi0;
            if (edge_s.fall) begin
                hi_q  <= 1'b0;
                cyc_q <= cyc_n;
            end else if (edge_s.rise) begin
                hi_q <= 1'b1;
            end
        end
    end

    // R5
    cyc_start_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_s.fall && line_start) |=> (cyc_q == '0));

    // R9
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_s.fall |=> $stable(cyc_q));

endmodule

// File: rtl/vpa_longline.sv
module vpa_longline
    import vpa_pkg::*;
#(
    parameter line_t FIRST_LINE = 9'h030,
    parameter line_t LAST_LINE  = 9'h0F7
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  logic    line_start,
    input  line_t   scan_line,
    input  scroll_t fine_scroll,
    input  logic    disp_on,
    output logic    long_now
);

    logic bad_q;
    logic hit;

    always_comb begin
        hit      = long_line_hit(scan_line, fine_scroll, disp_on, FIRST_LINE, LAST_LINE);
        long_now = line_start ? hit : bad_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bad_q <= 1'b0;
        else if (step && line_start)
            bad_q <= hit;
    end

    // R3
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(step && line_start) |=> $stable(bad_q));

    // R3
    bad_off_chk: assert property (@(posedge clk) disable iff (rst)
        (step && line_start && !disp_on) |=> !bad_q);

endmodule

// File: rtl/vpa_sched.sv
module vpa_sched #(
    parameter int LEAD  = 3,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [LEN_W-1:0] req_len,
    output logic             need_q,
    output logic             busy_n
);

    logic [LEAD-1:0][LEN_W-1:0] dly_q;
    logic [LEN_W-1:0]           rem_q;
    logic [LEN_W-1:0]           rem_n;
    logic                       pend_n;

    always_comb begin
        rem_n = ((rem_q != '0) ? (rem_q - LEN_W'(1)) : '0) + dly_q[LEAD-1];
        pend_n = (req_len != '0);
        for (int i = 0; i < LEAD - 1; i++)
            pend_n = pend_n | (dly_q[i] != '0);
        busy_n = (rem_n != '0) | pend_n;
    end

    generate
        for (genvar g = 0; g < LEAD; g++) begin : g_dly
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst)
                        dly_q[g] <= '0;
                    else if (step)
                        dly_q[g] <= req_len;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst)
                        dly_q[g] <= '0;
                    else if (step)
                        dly_q[g] <= dly_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            need_q <= 1'b0;
        end else if (step) begin
            rem_q  <= rem_n;
            need_q <= (rem_n != '0);
        end
    end

    // R4
    due_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (step && dly_q[LEAD-1] != '0) |=> need_q);

    // R7
    queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && rem_q > LEN_W'(1)) |=> need_q);

endmodule

// File: rtl/vpa_arbiter.sv
module vpa_arbiter
    import vpa_pkg::*;
#(
    parameter int    NUM_SPR      = 8,
    parameter int    CYC_PER_LINE = 63,
    parameter int    MTX_FIRST    = 15,
    parameter int    MTX_LEN      = 40,
    parameter int    SPR_LEN      = 2,
    parameter int    LEAD         = 3,
    parameter line_t FIRST_LINE   = 9'h030,
    parameter line_t LAST_LINE    = 9'h0F7,
    localparam int   CYC_W        = $clog2(CYC_PER_LINE),
    localparam int   LEN_W        = $clog2(MTX_LEN + SPR_LEN * NUM_SPR + 1) + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               phi0,
    input  logic               line_start,
    input  logic [LINE_W-1:0]  scan_line,
    input  logic [SCROLL_W-1:0] fine_scroll,
    input  logic               disp_on,
    input  logic [NUM_SPR-1:0] spr_on,
    input  logic [NUM_SPR-1:0] spr_slot,
    output logic               bus_ready,
    output logic               addr_grant
);

    phase_edge_t      edge_s;
    logic             hi_q;
    logic [CYC_W-1:0] cyc_n;
    logic             long_now;
    logic             mtx_ann;
    logic [LEN_W-1:0] spr_cnt;
    logic [LEN_W-1:0] req_len;
    logic             need_q;
    logic             busy_n;
    logic             ba_q;
    logic             aec_q;

    vpa_phase #(.CYC_PER_LINE(CYC_PER_LINE)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .phi0       (phi0),
        .line_start (line_start),
        .edge_s     (edge_s),
        .hi_q       (hi_q),
        .cyc_n      (cyc_n)
    );

    vpa_longline #(.FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE)) u_long (
        .clk         (clk),
        .rst         (rst),
        .step        (edge_s.fall),
        .line_start  (line_start),
        .scan_line   (scan_line),
        .fine_scroll (fine_scroll),
        .disp_on     (disp_on),
        .long_now    (long_now)
    );

    // Requests announced in this bus cycle, counted in claimed cycles
    always_comb begin
        mtx_ann = long_now && (cyc_n == CYC_W'(MTX_FIRST - LEAD));
        spr_cnt = '0;
        for (int i = 0; i < NUM_SPR; i++)
            spr_cnt = spr_cnt + LEN_W'(spr_on[i] & spr_slot[i]);
        req_len = (mtx_ann ? LEN_W'(MTX_LEN) : '0) + spr_cnt * LEN_W'(SPR_LEN);
    end

    vpa_sched #(.LEAD(LEAD), .LEN_W(LEN_W)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .step    (edge_s.fall),
        .req_len (req_len),
        .need_q  (need_q),
        .busy_n  (busy_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ba_q  <= 1'b1;
            aec_q <= 1'b1;
        end else if (edge_s.fall) begin
            ba_q  <= ~busy_n;
            aec_q <= 1'b0;
        end else if (edge_s.rise) begin
            aec_q <= ~need_q;
        end
    end

    assign bus_ready  = ba_q;
    assign addr_grant = aec_q;

    // R9
    ba_step_only_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_s.fall |=> $stable(ba_q));

    // R9
    aec_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(edge_s.fall || edge_s.rise) |=> $stable(aec_q));

    // R2
    aec_low_half_chk: assert property (@(posedge clk) disable iff (rst)
        edge_s.fall |=> !aec_q);

    // R4
    aec_needs_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_q && !aec_q) |-> !ba_q);

endmodule

// File: tb/tb_vpa_arbiter.sv
module tb_vpa_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phi0 = 1'b1;
    logic       line_start = 1'b0;
    logic [8:0] scan_line = '0;
    logic [2:0] fine_scroll = '0;
    logic       disp_on = 1'b0;
    logic [7:0] spr_on = '0;
    logic [7:0] spr_slot = '0;
    logic       bus_ready;
    logic       addr_grant;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vpa_arbiter dut (
        .clk         (clk),
        .rst         (rst),
        .phi0        (phi0),
        .line_start  (line_start),
        .scan_line   (scan_line),
        .fine_scroll (fine_scroll),
        .disp_on     (disp_on),
        .spr_on      (spr_on),
        .spr_slot    (spr_slot),
        .bus_ready   (bus_ready),
        .addr_grant  (addr_grant)
    );

    // Bench model: absolute bus cycles that are claimed
    bit need_a [0:4095];
    bit mtx_a  [0:4095];
    bit q_a    [0:4095];
    int t = 0;
    int next_free = 0;
    int cyc_b = 0;
    bit bad_b = 0;

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s t=%0d cyc=%0d actual=%0b expected=%0b", tag, what, t, cyc_b, act, exp);
        end
    endtask

    task automatic claim(input int first, input int len, input bit is_mtx);
        int start;
        start = (first > next_free) ? first : next_free;
        for (int k = 0; k < len; k++) begin
            need_a[start + k] = 1'b1;
            mtx_a[start + k]  = is_mtx;
            q_a[start + k]    = (start > first);
        end
        next_free = start + len;
    endtask

    task automatic run_cycle(input bit ls, input logic [8:0] ln, input logic [2:0] sc,
                             input bit de, input logic [7:0] en, input logic [7:0] slot);
        logic exp_ba;
        logic ba_mid;
        string tag;
        @(negedge clk);
        phi0 = 1'b0;
        line_start = ls;
        scan_line = ln;
        fine_scroll = sc;
        disp_on = de;
        spr_on = en;
        spr_slot = slot;
        cyc_b = ls ? 0 : cyc_b + 1;
        if (ls)
            bad_b = de && (ln >= 9'h030) && (ln <= 9'h0F7) && (ln[2:0] == sc);
        if (bad_b && cyc_b == 12)
            claim(t + 3, 40, 1'b1);
        if ($countones(en & slot) != 0)
            claim(t + 3, 2 * $countones(en & slot), 1'b0);
        exp_ba = ~(need_a[t] | need_a[t+1] | need_a[t+2] | need_a[t+3]);
        if (need_a[t])
            tag = q_a[t] ? "R7" : (mtx_a[t] ? "R5" : "R6");
        else if (!exp_ba)
            tag = "R4";
        else if (t > 0 && need_a[t-1])
            tag = "R8";
        else
            tag = "R2";
        @(negedge clk);
        @(negedge clk);
        ba_mid = bus_ready;
        check(tag, bus_ready, exp_ba, "bus_ready low half");
        check("R2", addr_grant, 1'b0, "addr_grant low half");
        @(negedge clk);
        check("R9", bus_ready, ba_mid, "bus_ready stable within half");
        @(negedge clk);
        phi0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (cyc_b == 15)
            tag = "R3";
        check(tag, addr_grant, ~need_a[t], "addr_grant high half");
        check("R9", bus_ready, ba_mid, "bus_ready stable over high half");
        @(negedge clk);
        t++;
    endtask

    // mode 0: no slots; 1: staggered slots from cycle 48; 2: all slots at cycle 30
    task automatic run_line(input logic [8:0] ln, input logic [2:0] sc, input bit de,
                            input logic [7:0] en, input int mode);
        for (int c = 0; c < 63; c++) begin
            logic [7:0] slot;
            slot = '0;
            if (mode == 1) begin
                for (int i = 0; i < 8; i++)
                    if (c == 48 + 2 * i) slot[i] = 1'b1;
            end else if (mode == 2) begin
                if (c == 30) slot = 8'hFF;
            end
            run_cycle(c == 0, ln, sc, de, en, slot);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        // R1
        check("R1", bus_ready, 1'b1, "bus_ready in reset");
        check("R1", addr_grant, 1'b1, "addr_grant in reset");
        rst = 1'b0;

        // R3: display off, otherwise matching line
        for (int n = 0; n < 2; n++)
            run_line(9'h033, 3'd3, 1'b0, 8'h00, 0);
        // R2 idle with disabled sprites announcing (R6 ignored)
        run_line(9'h040, 3'd1, 1'b1, 8'h00, 1);
        // Sweep around the top of the band
        for (int ln = 9'h02E; ln <= 9'h03F; ln++)
            run_line(9'(ln), 3'd3, 1'b1, 8'hA5, ln % 3);
        // Scroll sweep on the first band lines
        for (int sc = 0; sc < 8; sc++)
            run_line(9'(9'h030 + sc), 3'(sc), 1'b1, 8'hFF, (sc % 2) ? 1 : 2);
        // Bottom of the band
        for (int ln = 9'h0F5; ln <= 9'h0F9; ln++)
            run_line(9'(ln), 3'(ln % 8), 1'b1, 8'h3C, 2);
        // Band scroll mismatch and a quiet tail
        run_line(9'h080, 3'd2, 1'b1, 8'h00, 0);
        run_line(9'h081, 3'd2, 1'b1, 8'h00, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule